// File: doc/BRIEF.md
# Out-of-Sequence Transmit Descriptor Arbiter

This block sits ahead of an Ethernet transmit engine and decides which buffer descriptor is handed over next. It weighs one priority descriptor slot, meant for urgent frames such as pause frames, against the head entry of the normal circular transmit ring. The priority slot has the same fields as a ring entry: a 16-bit control word, a 16-bit byte count and a 32-bit buffer address. The choice is made only at a frame boundary, when the transmitter is idle or is signalling the end of its current frame. A frame already on the wire is never cut short.

When the slot is ready it always wins. A slot whose last-buffer bit is clear is refused and flagged instead of being sent. After a slot frame finishes, the block requests that its ready bit be cleared. It also ignores the slot until that bit has been seen low, so one descriptor never produces two frames. Ring frames advance a wrapping ring index. Slot frames leave the index where it is.

Top module: `oob_txd_arbiter`

## Requirements
- R1: While reset is low, and right after it is released, tx_start, sel_is_slot, txc_event, slot_clr and oob_err are 0 and ring_idx is 0.
- R2: Control words use bit 15 as ready, bit 12 as interrupt-on-completion and bit 11 as last-buffer. A new frame is launched only when no frame is in flight or tx_done is high in the same cycle. Launching a frame raises tx_start for one cycle on the next clock edge.
- R3: If the slot is ready and has its last-buffer bit set at a boundary, it is launched with sel_is_slot=1, and sel_ctl/sel_len/sel_ptr carry the slot fields. This holds whether or not the ring head is ready.
- R4: If the slot is not ready and the ring head's ready bit is set, the ring head is launched with sel_is_slot=0 and the ring fields on the sel outputs. Slot interrupt and last bits have no effect in that case.
- R5: Each ring launch advances ring_idx by one, wrapping from RING_DEPTH-1 to 0. Slot launches and refusals leave ring_idx unchanged.
- R6: A slot frame is sent once. slot_clr pulses one cycle after its tx_done. While the slot's ready bit stays high, no further slot frame starts. Once the ready bit has been seen low and is set again, the slot is eligible again.
- R7: A ready slot with its last-buffer bit clear is refused. oob_err and slot_clr pulse for one cycle, no frame starts in that cycle, and the ring index does not move.
- R8: txc_event pulses for one cycle after the tx_done that ends a frame whose interrupt bit was set. It stays low for frames without the bit.
- R9: With neither the slot nor the ring head ready, no frame starts.
- R10: tx_done while no frame is in flight is ignored: no txc_event and no slot_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_ctl | input | CTL_W | Priority slot control word |
| slot_len | input | LEN_W | Priority slot byte count |
| slot_ptr | input | PTR_W | Priority slot buffer address |
| ring_ctl | input | CTL_W | Ring head control word |
| ring_len | input | LEN_W | Ring head byte count |
| ring_ptr | input | PTR_W | Ring head buffer address |
| tx_done | input | 1 | Transmitter finished the current frame |
| ring_idx | output | IDX_W | Index of the current ring head |
| tx_start | output | 1 | Launch pulse for the selected descriptor |
| sel_is_slot | output | 1 | Selected descriptor came from the priority slot |
| sel_ctl | output | CTL_W | Selected control word |
| sel_len | output | LEN_W | Selected byte count |
| sel_ptr | output | PTR_W | Selected buffer address |
| txc_event | output | 1 | Transmit-complete event |
| slot_clr | output | 1 | Request to clear the slot's ready bit |
| oob_err | output | 1 | Slot descriptor refused (not last-buffer) |

## Verification
The selection is tried over combinations of slot ready, last-buffer and interrupt bits against ring ready and interrupt bits. This separates priority over a ready ring, fallback to the ring, refusal of a multi-buffer slot, and the idle case. Slot control bits are also set while the slot's ready bit is low, to show that they are ignored. Directed sequences offer the slot mid-frame and at the done cycle, to separate non-preemption from boundary launch. They also hold the slot's ready bit high after completion to expose a resend, drive the ring index through its wrap, and pulse tx_done while idle.

// File: rtl/oob_txd_pkg.sv
package oob_txd_pkg;

   typedef enum logic [1:0] {
      PICK_NONE   = 2'd0,
      PICK_RING   = 2'd1,
      PICK_SLOT   = 2'd2,
      PICK_REFUSE = 2'd3
   } pick_e;

   function automatic pick_e decide(input logic at_boundary,
                                    input logic slot_good,
                                    input logic slot_bad,
                                    input logic ring_ready);
      if (!at_boundary)    return PICK_NONE;
      else if (slot_good)  return PICK_SLOT;
      else if (slot_bad)   return PICK_REFUSE;
      else if (ring_ready) return PICK_RING;
      else                 return PICK_NONE;
   endfunction

endpackage

// File: rtl/oob_slot_gate.sv
module oob_slot_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy,
   input  logic last,
   input  logic take,
   output logic good,
   output logic bad
);
   logic spent_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     spent_q <= 1'b0;
      else if (take)  spent_q <= 1'b1;
      else if (!rdy)  spent_q <= 1'b0;
   end

   assign good = rdy & ~spent_q & last;
   assign bad  = rdy & ~spent_q & ~last;

   // R6: once taken, the slot stays ineligible while ready remains high
   a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rdy) |=> !(good || bad));

endmodule

// File: rtl/oob_ring_index.sv
module oob_ring_index #(
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [IW-1:0] idx
);
   localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

   initial begin
      if (DEPTH < 2) $error("ring depth must be at least 2");
   end

   logic [IW-1:0] idx_q;

   generate
      if ((1 << IW) == DEPTH) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)   idx_q <= '0;
            else if (adv) idx_q <= idx_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   idx_q <= '0;
            else if (adv) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
         end
      end
   endgenerate

   assign idx = idx_q;

   a_r5_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (idx == (($past(idx) == LAST_IDX) ? '0 : $past(idx) + 1'b1)));

   a_r5_ring_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(idx));

endmodule

// File: rtl/oob_txd_arbiter.sv
module oob_txd_arbiter #(
   parameter int CTL_W      = 16,
   parameter int LEN_W      = 16,
   parameter int PTR_W      = 32,
   parameter int RING_DEPTH = 8,
   parameter int RDY_BIT    = 15,
   parameter int INT_BIT    = 12,
   parameter int LAST_BIT   = 11,
   localparam int IDX_W     = $clog2(RING_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] slot_ctl,
   input  logic [LEN_W-1:0] slot_len,
   input  logic [PTR_W-1:0] slot_ptr,
   input  logic [CTL_W-1:0] ring_ctl,
   input  logic [LEN_W-1:0] ring_len,
   input  logic [PTR_W-1:0] ring_ptr,
   input  logic             tx_done,
   output logic [IDX_W-1:0] ring_idx,
   output logic             tx_start,
   output logic             sel_is_slot,
   output logic [CTL_W-1:0] sel_ctl,
   output logic [LEN_W-1:0] sel_len,
   output logic [PTR_W-1:0] sel_ptr,
   output logic             txc_event,
   output logic             slot_clr,
   output logic             oob_err
);
   import oob_txd_pkg::*;

   initial begin
      if (RDY_BIT >= CTL_W || INT_BIT >= CTL_W || LAST_BIT >= CTL_W)
         $error("control bit position outside control word");
      if (RDY_BIT == INT_BIT || RDY_BIT == LAST_BIT || INT_BIT == LAST_BIT)
         $error("control bit positions must differ");
   end

   logic  busy_q, cur_slot_q, cur_int_q;
   logic  at_boundary, slot_good, slot_bad, finish;
   pick_e pick;

   assign at_boundary = ~busy_q | tx_done;
   assign finish      = busy_q & tx_done;
   assign pick        = decide(at_boundary, slot_good, slot_bad, ring_ctl[RDY_BIT]);

   oob_slot_gate u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .rdy  (slot_ctl[RDY_BIT]),
      .last (slot_ctl[LAST_BIT]),
      .take (pick == PICK_SLOT || pick == PICK_REFUSE),
      .good (slot_good),
      .bad  (slot_bad)
   );

   oob_ring_index #(.DEPTH(RING_DEPTH)) u_index (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (pick == PICK_RING),
      .idx  (ring_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         cur_slot_q  <= 1'b0;
         cur_int_q   <= 1'b0;
         tx_start    <= 1'b0;
         sel_is_slot <= 1'b0;
         sel_ctl     <= '0;
         sel_len     <= '0;
         sel_ptr     <= '0;
         txc_event   <= 1'b0;
         slot_clr    <= 1'b0;
         oob_err     <= 1'b0;
      end else begin
         tx_start  <= 1'b0;
         oob_err   <= (pick == PICK_REFUSE);
         txc_event <= finish & cur_int_q;
         slot_clr  <= (finish & cur_slot_q) | (pick == PICK_REFUSE);
         if (finish) busy_q <= 1'b0;
         if (pick == PICK_SLOT) begin
            busy_q      <= 1'b1;
            tx_start    <= 1'b1;
            sel_is_slot <= 1'b1;
            cur_slot_q  <= 1'b1;
            cur_int_q   <= slot_ctl[INT_BIT];
            sel_ctl     <= slot_ctl;
            sel_len     <= slot_len;
            sel_ptr     <= slot_ptr;
         end else if (pick == PICK_RING) begin
            busy_q      <= 1'b1;
            tx_start    <= 1'b1;
            sel_is_slot <= 1'b0;
            cur_slot_q  <= 1'b0;
            cur_int_q   <= ring_ctl[INT_BIT];
            sel_ctl     <= ring_ctl;
            sel_len     <= ring_len;
            sel_ptr     <= ring_ptr;
         end
      end
   end

   a_r2_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tx_done) |=> !tx_start);

   a_r3_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
      (at_boundary && slot_good && ring_ctl[RDY_BIT]) |=> (tx_start && sel_is_slot));

   a_r7_refuse_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      oob_err |-> (!tx_start && slot_clr));

   a_r8_txc_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      txc_event |-> $past(tx_done));

   a_r9_nothing_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_ctl[RDY_BIT] && !ring_ctl[RDY_BIT]) |=> !tx_start);

endmodule

// File: tb/oob_txd_arbiter_bench.sv
module oob_txd_arbiter_bench;
   localparam int DEPTH = 5;
   localparam int IW    = $clog2(DEPTH);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] slot_ctl = '0, slot_len = '0, ring_ctl = '0, ring_len = '0;
   logic [31:0] slot_ptr = '0, ring_ptr = '0;
   logic        tx_done = 1'b0;
   logic [IW-1:0] ring_idx;
   logic        tx_start, sel_is_slot, txc_event, slot_clr, oob_err;
   logic [15:0] sel_ctl, sel_len;
   logic [31:0] sel_ptr;

   int errors = 0;
   int checks = 0;
   int exp_idx = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   oob_txd_arbiter #(.RING_DEPTH(DEPTH)) u_oob_txd_arbiter (
      .clk(clk), .rst_n(rst_n),
      .slot_ctl(slot_ctl), .slot_len(slot_len), .slot_ptr(slot_ptr),
      .ring_ctl(ring_ctl), .ring_len(ring_len), .ring_ptr(ring_ptr),
      .tx_done(tx_done), .ring_idx(ring_idx), .tx_start(tx_start),
      .sel_is_slot(sel_is_slot), .sel_ctl(sel_ctl), .sel_len(sel_len),
      .sel_ptr(sel_ptr), .txc_event(txc_event), .slot_clr(slot_clr),
      .oob_err(oob_err)
   );

   // {slot_rdy, slot_last, slot_int, ring_rdy, ring_int, exp_start, exp_slot, exp_err, exp_txc}
   localparam logic [8:0] VEC [10] = '{
      9'b11110_1101, 9'b11011_1100, 9'b00011_1001, 9'b00010_1000, 9'b10111_0010,
      9'b00000_0000, 9'b11100_1101, 9'b01110_1000, 9'b10000_0010, 9'b00011_1001
   };

   function automatic logic [15:0] mk_ctl(input logic r, input logic l, input logic i);
      return 16'h0000 | (16'(r) << 15) | (16'(i) << 12) | (16'(l) << 11);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_frame(input logic exp_txc, input logic exp_clr, input string req);
      tx_done = 1'b1;
      step();
      tx_done = 1'b0;
      chk({req, " txc_event after done"}, 32'(txc_event), 32'(exp_txc));
      chk({req, " slot_clr after done"}, 32'(slot_clr), 32'(exp_clr));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 reset tx_start", 32'(tx_start), 0);
      chk("R1 reset flags", 32'({txc_event, slot_clr, oob_err, sel_is_slot}), 0);
      rst_n = 1'b1;
      step();
      chk("R1 after release start", 32'(tx_start), 0);
      chk("R1 after release idx", 32'(ring_idx), 0);

      // R3 R4 R7 R8 R9: vector walk
      for (int v = 0; v < 10; v++) begin
         logic [8:0] e;
         e = VEC[v];
         slot_ctl = mk_ctl(e[8], e[7], e[6]);
         slot_len = 16'h0040 + 16'(v);
         slot_ptr = 32'hA000_0000 + 32'(v);
         ring_ctl = mk_ctl(e[5], 1'b1, e[4]);
         ring_len = 16'h0200 + 16'(v);
         ring_ptr = 32'hB000_0000 + 32'(v);
         step();
         if (e[3] && !e[2]) exp_idx = (exp_idx + 1) % DEPTH;
         chk("R9 R3 R4 tx_start", 32'(tx_start), 32'(e[3]));
         chk("R7 oob_err", 32'(oob_err), 32'(e[1]));
         chk("R5 ring_idx", 32'(ring_idx), 32'(exp_idx));
         if (e[1]) chk("R7 slot_clr on refuse", 32'(slot_clr), 1);
         if (e[3]) begin
            chk("R3 R4 sel_is_slot", 32'(sel_is_slot), 32'(e[2]));
            chk("R3 R4 sel_ptr", sel_ptr, e[2] ? 32'hA000_0000 + 32'(v) : 32'hB000_0000 + 32'(v));
            chk("R3 R4 sel_len", 32'(sel_len), e[2] ? 32'h40 + 32'(v) : 32'h200 + 32'(v));
         end
         slot_ctl = '0;
         ring_ctl = '0;
         if (e[3]) finish_frame(e[0], e[2], "R8 R6");
         step();
      end

      // R10: done while idle ignored
      tx_done = 1'b1;
      step();
      tx_done = 1'b0;
      chk("R10 idle done txc", 32'(txc_event), 0);
      chk("R10 idle done slot_clr", 32'(slot_clr), 0);

      // R5 wrap: index now at DEPTH-1 after four ring launches
      chk("R5 index before wrap", 32'(ring_idx), 32'(exp_idx));
      ring_ctl = mk_ctl(1'b1, 1'b1, 1'b0);
      step();
      ring_ctl = '0;
      exp_idx = (exp_idx + 1) % DEPTH;
      chk("R5 index wrap", 32'(ring_idx), 32'(exp_idx));

      // R2: slot offered mid-frame waits, then launches at the done cycle
      slot_ctl = mk_ctl(1'b1, 1'b1, 1'b0);
      slot_ptr = 32'hC0DE_0001;
      step();
      chk("R2 no preempt", 32'(tx_start), 0);
      step();
      chk("R2 still no preempt", 32'(tx_start), 0);
      tx_done = 1'b1;
      step();
      tx_done = 1'b0;
      chk("R2 launch at done", 32'(tx_start), 1);
      chk("R2 slot selected at done", 32'(sel_is_slot), 1);
      chk("R5 slot keeps index", 32'(ring_idx), 32'(exp_idx));
      // R6: ready held high after completion
      finish_frame(1'b0, 1'b1, "R6");
      chk("R6 no resend same cycle", 32'(tx_start), 0);
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R6 no resend while ready held", 32'(tx_start), 0);
      end
      slot_ctl = '0;
      step();
      slot_ctl = mk_ctl(1'b1, 1'b1, 1'b1);
      step();
      chk("R6 rearmed slot launches", 32'(tx_start), 1);
      chk("R6 rearmed slot selected", 32'(sel_is_slot), 1);
      slot_ctl = '0;
      finish_frame(1'b1, 1'b1, "R8 R6");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule